// File: doc/BRIEF.md
# Audio Clock and Data Routing Crossbar

This block sits between four audio parties: an S/PDIF receiver that works as a clock master, an S/PDIF transmitter that works as a slave, a stereo codec with separate ADC and DAC serial ports, and an external DSP connector. A free-running oscillator is one more master-clock source. The block routes one master clock, the frame clocks (LRCK), the bit clocks (SCLK) and the serial data among these parties. A setup code selects one of thirteen routing configurations.

Each configuration chooses three things separately: where the master clock comes from, which party masters the ADC subclocks, and which party masters the DAC subclocks and supplies the DAC data. Every pin that can change direction is split into a value output and an output-enable. The enable depends only on the captured configuration, so the block never drives a pin that another party is driving.

The setup code is captured on the `clk` edges that occur while the active-low reset is held. It is then frozen until the next reset. Until the first clock edge after reset is released, every routed output is undriven. The routing itself is purely combinational from source pins to destination pins.

Top module: `audio_route_matrix`

## Requirements
- R1: `setup_i` is sampled on each rising `clk` edge while `rst_n` is low, and the last value sampled is used. Changing `setup_i` after reset is released has no effect on any output until the next reset.
- R2: While `rst_n` is low, and until the first rising `clk` edge after it rises, every `*_oe` output is 0 and every `*_o` output is 0.
- R3: Once the block is active, `tx_sdata_o` and `dsp_sdata_o` are both enabled and equal `adc_sdata_i`, whatever the captured code, including invalid codes.
- R4: Codes 13, 14 and 15 are invalid. For these codes every output except the two ADC data outputs of R3 has enable 0 and value 0.
- R5: The codec master clock `codec_mclk_o` is taken from `rx_mclk_i` for codes 0 to 2, from `osc_mclk_i` for codes 3, 4, 8, 9 and 11, and from `dsp_mclk_i` for codes 5, 6, 7, 10 and 12. `tx_mclk_o` carries the same clock with the same enable.
- R6: The ADC subclocks come from the receiver for code 0 and from the DSP ADC clock pins for codes 1, 4, 6, 7, 8, 9 and 10. For codes 2, 3, 5, 11 and 12 the codec ADC is the subclock master. In that case `adc_lrck_oe` and `adc_sclk_oe` are 0. In every other valid code they are 1.
- R7: The DAC subclocks come from the receiver for codes 0 to 2, from the codec ADC clocks (`adc_lrck_i`, `adc_sclk_i`) for codes 3 and 5, from the DSP ADC clock pins for codes 4 and 6 to 8, and from the DSP DAC clock pins for codes 9 to 12.
- R8: The DAC data comes from `rx_sdata_i` for codes 0 to 2, from `adc_sdata_i` for codes 3 to 6 (loopback), and from `dsp_sdata_i` for codes 7 to 12.
- R9: `tx_lrck_o` and `tx_sclk_o` are enabled for every valid code and carry the ADC subclocks from the same source as R6. When the codec ADC is the master, they carry `adc_lrck_i` and `adc_sclk_i`.
- R10: The DSP ADC clock pins are driven outward only for codes 11 and 12, carrying `adc_lrck_i` and `adc_sclk_i`. For all other codes they are inputs.
- R11: The block never drives a pin that is acting as a clock source. It drives the codec ADC clock pins only when the codec ADC is not the master. It drives the DSP ADC clock pins only when no route reads them.
- R12: Every routed value follows its source input within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to capture the setup code and the active flag |
| rst_n | input | 1 | Active-low asynchronous reset; setup capture window |
| setup_i | input | CODE_W | Routing setup code |
| rx_mclk_i | input | 1 | Receiver recovered master clock |
| rx_lrck_i | input | 1 | Receiver frame clock |
| rx_sclk_i | input | 1 | Receiver bit clock |
| rx_sdata_i | input | 1 | Receiver serial data |
| osc_mclk_i | input | 1 | Oscillator master clock |
| dsp_mclk_i | input | 1 | DSP master clock |
| dsp_adc_lrck_i | input | 1 | DSP ADC-side frame clock, pin input path |
| dsp_adc_sclk_i | input | 1 | DSP ADC-side bit clock, pin input path |
| dsp_dac_lrck_i | input | 1 | DSP DAC-side frame clock |
| dsp_dac_sclk_i | input | 1 | DSP DAC-side bit clock |
| dsp_sdata_i | input | 1 | DSP serial data toward the DAC |
| adc_lrck_i | input | 1 | Codec ADC frame clock, pin input path |
| adc_sclk_i | input | 1 | Codec ADC bit clock, pin input path |
| adc_sdata_i | input | 1 | Codec ADC serial data |
| codec_mclk_o | output | 1 | Codec master clock |
| codec_mclk_oe | output | 1 | Enable for codec_mclk_o |
| tx_mclk_o | output | 1 | Transmitter master clock |
| tx_mclk_oe | output | 1 | Enable for tx_mclk_o |
| adc_lrck_o | output | 1 | Codec ADC frame clock, pin output path |
| adc_lrck_oe | output | 1 | Enable for adc_lrck_o |
| adc_sclk_o | output | 1 | Codec ADC bit clock, pin output path |
| adc_sclk_oe | output | 1 | Enable for adc_sclk_o |
| dac_lrck_o | output | 1 | Codec DAC frame clock |
| dac_lrck_oe | output | 1 | Enable for dac_lrck_o |
| dac_sclk_o | output | 1 | Codec DAC bit clock |
| dac_sclk_oe | output | 1 | Enable for dac_sclk_o |
| dac_sdata_o | output | 1 | Codec DAC serial data |
| dac_sdata_oe | output | 1 | Enable for dac_sdata_o |
| tx_lrck_o | output | 1 | Transmitter frame clock |
| tx_lrck_oe | output | 1 | Enable for tx_lrck_o |
| tx_sclk_o | output | 1 | Transmitter bit clock |
| tx_sclk_oe | output | 1 | Enable for tx_sclk_o |
| tx_sdata_o | output | 1 | Transmitter serial data |
| tx_sdata_oe | output | 1 | Enable for tx_sdata_o |
| dsp_sdata_o | output | 1 | ADC serial data toward the DSP |
| dsp_sdata_oe | output | 1 | Enable for dsp_sdata_o |
| dsp_adc_lrck_o | output | 1 | DSP ADC-side frame clock, pin output path |
| dsp_adc_lrck_oe | output | 1 | Enable for dsp_adc_lrck_o |
| dsp_adc_sclk_o | output | 1 | DSP ADC-side bit clock, pin output path |
| dsp_adc_sclk_oe | output | 1 | Enable for dsp_adc_sclk_o |

## Verification
Only two results are registered. The captured code settles on the edges seen during reset. The enables appear one rising edge after `rst_n` is released. The bench therefore changes reset at falling edges and checks the quiet state both during reset and in the half cycle after release. Every routed value is due in the same cycle as its source, so the bench changes the source pins and samples 1 time unit later, with no clock edge in between. Each of the 16 codes is swept with eight source patterns, and the expected source of every output is worked out from the requirement tables.

// File: rtl/arm_route_pkg.sv
package arm_route_pkg;

   localparam int ROUTE_CODE_W = 4;
   localparam int ROUTE_NUM_CFG = 13;

   typedef enum logic [1:0] {
      MSRC_NONE = 2'd0,
      MSRC_RX   = 2'd1,
      MSRC_OSC  = 2'd2,
      MSRC_DSP  = 2'd3
   } mclk_src_e;

   // index order matches the lane source vector built in the top
   typedef enum logic [2:0] {
      SUB_NONE  = 3'd0,
      SUB_RX    = 3'd1,
      SUB_DSPA  = 3'd2,
      SUB_DSPD  = 3'd3,
      SUB_CODEC = 3'd4
   } sub_src_e;

   typedef enum logic [1:0] {
      DAT_NONE = 2'd0,
      DAT_RX   = 2'd1,
      DAT_ADC  = 2'd2,
      DAT_DSP  = 2'd3
   } dat_src_e;

   typedef struct packed {
      mclk_src_e mclk;
      sub_src_e  adc_sub;
      sub_src_e  dac_sub;
      dat_src_e  dac_dat;
      logic      dsp_adc_out;
      logic      valid;
   } route_cfg_t;

   function automatic route_cfg_t mk_cfg(mclk_src_e m, sub_src_e a, sub_src_e d,
                                         dat_src_e t, logic o);
      route_cfg_t c;
      c.mclk        = m;
      c.adc_sub     = a;
      c.dac_sub     = d;
      c.dac_dat     = t;
      c.dsp_adc_out = o;
      c.valid       = 1'b1;
      return c;
   endfunction

   function automatic route_cfg_t route_lookup(logic [ROUTE_CODE_W-1:0] code);
      case (code)
         4'd0:    return mk_cfg(MSRC_RX,  SUB_RX,    SUB_RX,    DAT_RX,  1'b0);
         4'd1:    return mk_cfg(MSRC_RX,  SUB_DSPA,  SUB_RX,    DAT_RX,  1'b0);
         4'd2:    return mk_cfg(MSRC_RX,  SUB_CODEC, SUB_RX,    DAT_RX,  1'b0);
         4'd3:    return mk_cfg(MSRC_OSC, SUB_CODEC, SUB_CODEC, DAT_ADC, 1'b0);
         4'd4:    return mk_cfg(MSRC_OSC, SUB_DSPA,  SUB_DSPA,  DAT_ADC, 1'b0);
         4'd5:    return mk_cfg(MSRC_DSP, SUB_CODEC, SUB_CODEC, DAT_ADC, 1'b0);
         4'd6:    return mk_cfg(MSRC_DSP, SUB_DSPA,  SUB_DSPA,  DAT_ADC, 1'b0);
         4'd7:    return mk_cfg(MSRC_DSP, SUB_DSPA,  SUB_DSPA,  DAT_DSP, 1'b0);
         4'd8:    return mk_cfg(MSRC_OSC, SUB_DSPA,  SUB_DSPA,  DAT_DSP, 1'b0);
         4'd9:    return mk_cfg(MSRC_OSC, SUB_DSPA,  SUB_DSPD,  DAT_DSP, 1'b0);
         4'd10:   return mk_cfg(MSRC_DSP, SUB_DSPA,  SUB_DSPD,  DAT_DSP, 1'b0);
         4'd11:   return mk_cfg(MSRC_OSC, SUB_CODEC, SUB_DSPD,  DAT_DSP, 1'b1);
         4'd12:   return mk_cfg(MSRC_DSP, SUB_CODEC, SUB_DSPD,  DAT_DSP, 1'b1);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/arm_setup_latch.sv
module arm_setup_latch #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] setup_i,
   output logic [CODE_W-1:0] code_o,
   output logic              live_o
);

   generate
      if (CODE_W < 1) begin : g_bad_w
         $error("arm_setup_latch: CODE_W must be positive");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic              live_q;

   // capture window: every edge seen while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= setup_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign code_o = code_q;
   assign live_o = live_q;

   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(live_q)) |-> $stable(code_q));   // R1

endmodule

// File: rtl/arm_route_decode.sv
module arm_route_decode
   import arm_route_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int NUM_CFG = ROUTE_NUM_CFG
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              live_i,
   output route_cfg_t        cfg_o
);

   generate
      if (CODE_W < ROUTE_CODE_W) begin : g_bad_w
         $error("arm_route_decode: CODE_W too narrow for the route table");
      end
      if (NUM_CFG > ROUTE_NUM_CFG) begin : g_bad_n
         $error("arm_route_decode: NUM_CFG exceeds table size");
      end
   endgenerate

   always_comb begin
      cfg_o = '0;
      if (live_i && (int'(code_i) < NUM_CFG)) begin
         cfg_o = route_lookup(code_i[ROUTE_CODE_W-1:0]);
      end
   end

endmodule

// File: rtl/arm_sel_mux.sv
module arm_sel_mux #(
   parameter int N_SRC = 4,
   localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] src_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             en_i,
   output logic             y_o,
   output logic             oe_o
);

   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("arm_sel_mux: N_SRC must be at least 2");
      end
   endgenerate

   always_comb begin
      y_o = 1'b0;
      if (en_i && (int'(sel_i) < N_SRC)) y_o = src_i[sel_i];
   end

   assign oe_o = en_i;

endmodule

// File: rtl/audio_route_matrix.sv
module audio_route_matrix
   import arm_route_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int NUM_CFG = ROUTE_NUM_CFG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] setup_i,
   input  logic              rx_mclk_i,
   input  logic              rx_lrck_i,
   input  logic              rx_sclk_i,
   input  logic              rx_sdata_i,
   input  logic              osc_mclk_i,
   input  logic              dsp_mclk_i,
   input  logic              dsp_adc_lrck_i,
   input  logic              dsp_adc_sclk_i,
   input  logic              dsp_dac_lrck_i,
   input  logic              dsp_dac_sclk_i,
   input  logic              dsp_sdata_i,
   input  logic              adc_lrck_i,
   input  logic              adc_sclk_i,
   input  logic              adc_sdata_i,
   output logic              codec_mclk_o,
   output logic              codec_mclk_oe,
   output logic              tx_mclk_o,
   output logic              tx_mclk_oe,
   output logic              adc_lrck_o,
   output logic              adc_lrck_oe,
   output logic              adc_sclk_o,
   output logic              adc_sclk_oe,
   output logic              dac_lrck_o,
   output logic              dac_lrck_oe,
   output logic              dac_sclk_o,
   output logic              dac_sclk_oe,
   output logic              dac_sdata_o,
   output logic              dac_sdata_oe,
   output logic              tx_lrck_o,
   output logic              tx_lrck_oe,
   output logic              tx_sclk_o,
   output logic              tx_sclk_oe,
   output logic              tx_sdata_o,
   output logic              tx_sdata_oe,
   output logic              dsp_sdata_o,
   output logic              dsp_sdata_oe,
   output logic              dsp_adc_lrck_o,
   output logic              dsp_adc_lrck_oe,
   output logic              dsp_adc_sclk_o,
   output logic              dsp_adc_sclk_oe
);

   localparam int LANES    = 2;   // lane 0 = frame clock, lane 1 = bit clock
   localparam int MCLK_SRC = 4;
   localparam int SUB_SRC  = 5;
   localparam int DAT_SRC  = 4;

   generate
      if (CODE_W < ROUTE_CODE_W) begin : g_bad_w
         $error("audio_route_matrix: CODE_W too narrow");
      end
      if (NUM_CFG < 1 || NUM_CFG > (1 << CODE_W)) begin : g_bad_n
         $error("audio_route_matrix: NUM_CFG out of range");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              live;
   route_cfg_t        cfg;

   arm_setup_latch #(.CODE_W(CODE_W)) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .setup_i (setup_i),
      .code_o  (code),
      .live_o  (live)
   );

   arm_route_decode #(.CODE_W(CODE_W), .NUM_CFG(NUM_CFG)) i_decode (
      .code_i (code),
      .live_i (live),
      .cfg_o  (cfg)
   );

   // ---------------- master clock ----------------
   logic mclk_y, mclk_oe;
   arm_sel_mux #(.N_SRC(MCLK_SRC)) i_mclk_mux (
      .src_i ({dsp_mclk_i, osc_mclk_i, rx_mclk_i, 1'b0}),
      .sel_i (cfg.mclk),
      .en_i  (cfg.mclk != MSRC_NONE),
      .y_o   (mclk_y),
      .oe_o  (mclk_oe)
   );
   assign codec_mclk_o  = mclk_y;
   assign codec_mclk_oe = mclk_oe;
   assign tx_mclk_o     = mclk_y;
   assign tx_mclk_oe    = mclk_oe;

   // ---------------- subclock lanes ----------------
   logic [LANES-1:0] rx_sub, dspa_sub, dspd_sub, adc_sub;
   assign rx_sub   = {rx_sclk_i,      rx_lrck_i};
   assign dspa_sub = {dsp_adc_sclk_i, dsp_adc_lrck_i};
   assign dspd_sub = {dsp_dac_sclk_i, dsp_dac_lrck_i};
   assign adc_sub  = {adc_sclk_i,     adc_lrck_i};

   logic codec_adc_drive;
   assign codec_adc_drive = (cfg.adc_sub == SUB_RX) || (cfg.adc_sub == SUB_DSPA);

   logic [LANES-1:0] cadc_y, cadc_oe, dac_y, dac_oe, tx_y, tx_oe, dspo_y, dspo_oe;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [SUB_SRC-1:0] lane_src;
         assign lane_src = {adc_sub[l], dspd_sub[l], dspa_sub[l], rx_sub[l], 1'b0};

         arm_sel_mux #(.N_SRC(SUB_SRC)) i_cadc_mux (
            .src_i (lane_src),
            .sel_i (cfg.adc_sub),
            .en_i  (codec_adc_drive),
            .y_o   (cadc_y[l]),
            .oe_o  (cadc_oe[l])
         );

         arm_sel_mux #(.N_SRC(SUB_SRC)) i_dac_mux (
            .src_i (lane_src),
            .sel_i (cfg.dac_sub),
            .en_i  (cfg.dac_sub != SUB_NONE),
            .y_o   (dac_y[l]),
            .oe_o  (dac_oe[l])
         );

         arm_sel_mux #(.N_SRC(SUB_SRC)) i_tx_mux (
            .src_i (lane_src),
            .sel_i (cfg.adc_sub),
            .en_i  (cfg.valid),
            .y_o   (tx_y[l]),
            .oe_o  (tx_oe[l])
         );

         assign dspo_y[l]  = cfg.dsp_adc_out & adc_sub[l];
         assign dspo_oe[l] = cfg.dsp_adc_out;
      end
   endgenerate

   assign adc_lrck_o      = cadc_y[0];
   assign adc_lrck_oe     = cadc_oe[0];
   assign adc_sclk_o      = cadc_y[1];
   assign adc_sclk_oe     = cadc_oe[1];
   assign dac_lrck_o      = dac_y[0];
   assign dac_lrck_oe     = dac_oe[0];
   assign dac_sclk_o      = dac_y[1];
   assign dac_sclk_oe     = dac_oe[1];
   assign tx_lrck_o       = tx_y[0];
   assign tx_lrck_oe      = tx_oe[0];
   assign tx_sclk_o       = tx_y[1];
   assign tx_sclk_oe      = tx_oe[1];
   assign dsp_adc_lrck_o  = dspo_y[0];
   assign dsp_adc_lrck_oe = dspo_oe[0];
   assign dsp_adc_sclk_o  = dspo_y[1];
   assign dsp_adc_sclk_oe = dspo_oe[1];

   // ---------------- serial data ----------------
   arm_sel_mux #(.N_SRC(DAT_SRC)) i_dac_dat_mux (
      .src_i ({dsp_sdata_i, adc_sdata_i, rx_sdata_i, 1'b0}),
      .sel_i (cfg.dac_dat),
      .en_i  (cfg.dac_dat != DAT_NONE),
      .y_o   (dac_sdata_o),
      .oe_o  (dac_sdata_oe)
   );

   assign tx_sdata_o   = live & adc_sdata_i;
   assign tx_sdata_oe  = live;
   assign dsp_sdata_o  = live & adc_sdata_i;
   assign dsp_sdata_oe = live;

   // ---------------- checks ----------------
   AST_QUIET_UNTIL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !live |-> !(codec_mclk_oe | tx_mclk_oe | adc_lrck_oe | adc_sclk_oe | dac_lrck_oe |
                  dac_sclk_oe | dac_sdata_oe | tx_lrck_oe | tx_sclk_oe | tx_sdata_oe |
                  dsp_sdata_oe | dsp_adc_lrck_oe | dsp_adc_sclk_oe));   // R2

   AST_ADC_DATA_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (tx_sdata_oe && dsp_sdata_oe && tx_sdata_o == adc_sdata_i &&
                dsp_sdata_o == adc_sdata_i));   // R3

   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (live && int'(code) >= NUM_CFG) |-> !(codec_mclk_oe | tx_mclk_oe | adc_lrck_oe |
         adc_sclk_oe | dac_lrck_oe | dac_sclk_oe | dac_sdata_oe | tx_lrck_oe |
         tx_sclk_oe | dsp_adc_lrck_oe | dsp_adc_sclk_oe));   // R4

   AST_TX_MCLK_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mclk_oe == codec_mclk_oe) && (tx_mclk_o == codec_mclk_o));   // R5

   AST_TX_FOLLOWS_CODEC: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lrck_oe && cfg.adc_sub == SUB_CODEC) |->
         (tx_lrck_o == adc_lrck_i && tx_sclk_o == adc_sclk_i));   // R9

   AST_CODEC_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_lrck_oe || adc_sclk_oe) |-> (cfg.adc_sub != SUB_CODEC));   // R11

   AST_DSP_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_adc_lrck_oe || dsp_adc_sclk_oe) |->
         (cfg.adc_sub != SUB_DSPA && cfg.dac_sub != SUB_DSPA));   // R11

endmodule

// File: tb/test_audio_route_matrix.sv
module test_audio_route_matrix;

   localparam int CLK_PERIOD = 10;
   localparam int NOUT       = 13;
   localparam int NSRC       = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] setup = 4'd0;
   logic [NSRC-1:0] s = '0;

   logic codec_mclk_o, codec_mclk_oe, tx_mclk_o, tx_mclk_oe;
   logic adc_lrck_o, adc_lrck_oe, adc_sclk_o, adc_sclk_oe;
   logic dac_lrck_o, dac_lrck_oe, dac_sclk_o, dac_sclk_oe, dac_sdata_o, dac_sdata_oe;
   logic tx_lrck_o, tx_lrck_oe, tx_sclk_o, tx_sclk_oe, tx_sdata_o, tx_sdata_oe;
   logic dsp_sdata_o, dsp_sdata_oe, dsp_adc_lrck_o, dsp_adc_lrck_oe;
   logic dsp_adc_sclk_o, dsp_adc_sclk_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_route_matrix i_audio_route_matrix (
      .clk(clk), .rst_n(rst_n), .setup_i(setup),
      .rx_mclk_i(s[0]), .rx_lrck_i(s[1]), .rx_sclk_i(s[2]), .rx_sdata_i(s[3]),
      .osc_mclk_i(s[4]), .dsp_mclk_i(s[5]), .dsp_adc_lrck_i(s[6]), .dsp_adc_sclk_i(s[7]),
      .dsp_dac_lrck_i(s[8]), .dsp_dac_sclk_i(s[9]), .dsp_sdata_i(s[10]),
      .adc_lrck_i(s[11]), .adc_sclk_i(s[12]), .adc_sdata_i(s[13]),
      .codec_mclk_o(codec_mclk_o), .codec_mclk_oe(codec_mclk_oe),
      .tx_mclk_o(tx_mclk_o), .tx_mclk_oe(tx_mclk_oe),
      .adc_lrck_o(adc_lrck_o), .adc_lrck_oe(adc_lrck_oe),
      .adc_sclk_o(adc_sclk_o), .adc_sclk_oe(adc_sclk_oe),
      .dac_lrck_o(dac_lrck_o), .dac_lrck_oe(dac_lrck_oe),
      .dac_sclk_o(dac_sclk_o), .dac_sclk_oe(dac_sclk_oe),
      .dac_sdata_o(dac_sdata_o), .dac_sdata_oe(dac_sdata_oe),
      .tx_lrck_o(tx_lrck_o), .tx_lrck_oe(tx_lrck_oe),
      .tx_sclk_o(tx_sclk_o), .tx_sclk_oe(tx_sclk_oe),
      .tx_sdata_o(tx_sdata_o), .tx_sdata_oe(tx_sdata_oe),
      .dsp_sdata_o(dsp_sdata_o), .dsp_sdata_oe(dsp_sdata_oe),
      .dsp_adc_lrck_o(dsp_adc_lrck_o), .dsp_adc_lrck_oe(dsp_adc_lrck_oe),
      .dsp_adc_sclk_o(dsp_adc_sclk_o), .dsp_adc_sclk_oe(dsp_adc_sclk_oe)
   );

   logic [NOUT-1:0] act_v, act_oe;
   assign act_v  = {dsp_adc_sclk_o, dsp_adc_lrck_o, dsp_sdata_o, tx_sdata_o, tx_sclk_o,
                    tx_lrck_o, dac_sdata_o, dac_sclk_o, dac_lrck_o, adc_sclk_o, adc_lrck_o,
                    tx_mclk_o, codec_mclk_o};
   assign act_oe = {dsp_adc_sclk_oe, dsp_adc_lrck_oe, dsp_sdata_oe, tx_sdata_oe, tx_sclk_oe,
                    tx_lrck_oe, dac_sdata_oe, dac_sclk_oe, dac_lrck_oe, adc_sclk_oe,
                    adc_lrck_oe, tx_mclk_oe, codec_mclk_oe};

   // ADC subclock source per R6, lane l: 0 frame, 1 bit
   function automatic int adc_src(int c, int l);
      if (c == 0) return 1 + l;
      if (c == 1 || c == 4 || c == 6 || c == 7 || c == 8 || c == 9 || c == 10) return 6 + l;
      if (c == 2 || c == 3 || c == 5 || c == 11 || c == 12) return 11 + l;
      return -1;
   endfunction

   // expected source index for output k under code c; -1 means undriven
   function automatic int exp_src(int c, int k);
      int a;
      case (k)
         0, 1: begin   // R5
            if (c <= 2) return 0;
            if (c == 3 || c == 4 || c == 8 || c == 9 || c == 11) return 4;
            if (c == 5 || c == 6 || c == 7 || c == 10 || c == 12) return 5;
            return -1;
         end
         2, 3: begin   // R6 / R11
            a = adc_src(c, k - 2);
            if (a == 1 || a == 2 || a == 6 || a == 7) return a;
            return -1;
         end
         4, 5: begin   // R7
            if (c <= 2) return 1 + (k - 4);
            if (c == 3 || c == 5) return 11 + (k - 4);
            if (c == 4 || (c >= 6 && c <= 8)) return 6 + (k - 4);
            if (c >= 9 && c <= 12) return 8 + (k - 4);
            return -1;
         end
         6: begin      // R8
            if (c <= 2) return 3;
            if (c <= 6) return 13;
            if (c <= 12) return 10;
            return -1;
         end
         7, 8: return adc_src(c, k - 7);          // R9
         9, 10: return 13;                        // R3
         11, 12: return (c == 11 || c == 12) ? 11 + (k - 11) : -1;   // R10
         default: return -1;
      endcase
   endfunction

   function automatic string req_of(int c, int k);
      if (c >= 13 && k != 9 && k != 10) return "R4";
      case (k)
         0, 1:   return "R5";
         2, 3:   return "R6";
         4, 5:   return "R7";
         6:      return "R8";
         7, 8:   return "R9";
         9, 10:  return "R3";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual oe/val=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic check_routes(int c, string tag);
      for (int k = 0; k < NOUT; k++) begin
         int e;
         logic [1:0] ex;
         e  = exp_src(c, k);
         ex = (e < 0) ? 2'b00 : {1'b1, s[e]};
         check((tag == "") ? req_of(c, k) : tag,
               $sformatf("code %0d out %0d", c, k), {act_oe[k], act_v[k]}, ex);
      end
   endtask

   task automatic check_quiet(string tag);
      total++;
      if (act_oe !== '0 || act_v !== '0) begin
         bad++;
         $display("FAIL %s quiet: actual oe=%b v=%b expected all zero", tag, act_oe, act_v);
      end
   endtask

   initial begin
      s = 14'h3fff;
      @(negedge clk);
      check_quiet("R2");
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         rst_n = 1'b0;
         setup = 4'(c);
         @(negedge clk);
         check_quiet("R2");
         @(negedge clk);
         rst_n = 1'b1;
         #1;
         check_quiet("R2");   // enables arrive only at the next rising edge
         @(negedge clk);
         setup = ~4'(c);      // R1: ignored until the next reset
         for (int p = 0; p < 8; p++) begin
            s = 14'((p + 1) * 7013) ^ 14'(p * p * 3 + c * 291);
            #1;               // R12: same cycle, no clock edge in between
            check_routes(c, "");
            @(negedge clk);
         end
         s = 14'h3fff;
         #1;
         check_routes(c, "R1");
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule